// File: doc/BRIEF.md
# I2S to TDM Lane Merger

This block collects four stereo I2S streams from audio converters and repacks them onto a pair of fixed-rate time-division-multiplexed serial lanes. Each lane sends one bit per clock and has a 256-bit frame of eight 32-bit slots. One lane of the pair carries the left samples and the other carries the right samples. Each slot holds a 24-bit sample, MSB first, followed by eight status bits.

The lane bit rate does not change with the audio rate. At double speed, two I2S word periods fall inside one lane frame, so the held samples are loaded into the lane shifter at both half-frame boundaries. At single speed, only one word period fits in a frame, so the samples are loaded once per frame and the four-slot group is sent twice.

A five-bit control register, written by software, does three things:
- It picks which one of three lane pairs is driven. Undriven lanes have their output enable low.
- It holds the double-speed and speed-select bits for the converters.
- It holds an active-high converter reset bit. Software asserts this bit and then clears it.

Top module: `tdm_lane_merger`

## Requirements
- R1: After reset all control fields are 0. No lane output enable is high, all lane data is 0, and `conv_rst`, `conv_dbl` and `conv_spd` are low.
- R2: A write with `cfg_we` loads `cfg_wdata`. Bits [1:0] select the pair (0 means none, 1/2/3 mean pair 0/1/2), bit 2 is double speed, bit 3 is converter speed select and bit 4 is converter reset. The outputs follow from the next cycle, and without a write they hold.
- R3: When the selection is p+1, lanes 2p and 2p+1 have their enables set. Every other lane has its enable low and drives 0, and at most one pair is ever enabled.
- R4: A lane frame is 256 bits with `lane_fsync` high in the cycle of bit 0. Slot s occupies bits 32s to 32s+31. The first 24 bits are the sample MSB first and the last 8 bits are its status.
- R5: Lane 2p carries the left samples of streams 0 to 3 in slots 0 to 3 (and 4 to 7). Lane 2p+1 carries the right samples in the same slots.
- R6: An I2S word starts on the strobe after `i2s_ws` changes. WS low marks a left word and WS high a right word. The first 24 bits after the start are kept, MSB first, and any later bits of the word are ignored.
- R7: In double speed, held samples are loaded into the lane shifter at bits 0 and 128. Slots 4 to 7 therefore carry samples captured during slots 0 to 3.
- R8: In single speed, held samples are loaded only at bit 0. Slots 4 to 7 repeat slots 0 to 3 even when new samples arrive during the first half.
- R9: The status byte for stream k is taken from `stat_in[8c+7:8c]`, where c = 2k for left and 2k+1 for right. It is loaded together with the samples and is 0 when `stat_in` is 0.
- R10: `conv_rst` follows register bit 4. Setting the bit and then clearing it gives a high pulse followed by low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write value |
| i2s_strb | input | 1 | I2S bit strobe, one cycle per serial bit |
| i2s_ws | input | 1 | I2S word select, low for left |
| i2s_sd | input | 4 | I2S serial data, one bit per stream |
| stat_in | input | 64 | Status byte per channel |
| lane_sd | output | 6 | Lane serial data, two lanes per pair |
| lane_oe | output | 6 | Lane output enables |
| lane_fsync | output | 1 | High in the cycle of frame bit 0 |
| conv_rst | output | 1 | Converter reset, active high |
| conv_dbl | output | 1 | Converter double-speed enable |
| conv_spd | output | 1 | Converter speed select |

## Verification
The bench loads a new sample set during the first half of a captured frame, in both speed modes.
- A design that loads at the half frame in single speed shows the new set in slots 4 to 7 instead of a repeat.
- A design that skips that load in double speed shows stale data there.

Garbage bits follow the 24 sample bits of each I2S word. A capture that keeps shifting would corrupt the samples.

Distinct status bytes per channel expose swapped lanes or misplaced status fields. The bench also compares the enables and data of the unselected lanes against zero, which exposes a wrong pair decode.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
    localparam int SAMP_W  = 24;
    localparam int STAT_W  = 8;
    localparam int STREAMS = 4;
    localparam int PAIRS   = 3;
    localparam int SEL_W   = 2;

    typedef struct packed {
        logic             conv_rst;
        logic             conv_spd;
        logic             dbl;
        logic [SEL_W-1:0] sel;
    } ctl_t;
endpackage

// File: rtl/tlm_ctl_reg.sv
module tlm_ctl_reg
    import tlm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [$bits(ctl_t)-1:0] wdata,
    output ctl_t                ctl
);
    typedef struct packed {
        ctl_t r;
    } state_t;

    state_t d, q;

    always_comb begin
        d = q;
        if (we) begin
            d.r = ctl_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctl = q.r;
endmodule

// File: rtl/tlm_i2s_rx.sv
module tlm_i2s_rx #(
    parameter int SAMP_W = tlm_pkg::SAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb,
    input  logic              ws,
    input  logic              sd,
    output logic [SAMP_W-1:0] left,
    output logic [SAMP_W-1:0] right
);
    localparam int CNT_W = $clog2(SAMP_W + 1);

    typedef struct packed {
        logic              last_ws;
        logic              word_ws;
        logic [CNT_W-1:0]  cnt;
        logic [SAMP_W-1:0] sh;
        logic [SAMP_W-1:0] left;
        logic [SAMP_W-1:0] right;
    } state_t;

    state_t d, q;

    always_comb begin
        d = q;
        if (strb) begin
            d.last_ws = ws;
            if (ws != q.last_ws) begin
                // this bit still belongs to the previous word
                d.cnt     = '0;
                d.word_ws = ws;
            end else if (q.cnt < CNT_W'(SAMP_W)) begin
                d.sh  = {q.sh[SAMP_W-2:0], sd};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(SAMP_W - 1)) begin
                    if (q.word_ws) begin
                        d.right = d.sh;
                    end else begin
                        d.left = d.sh;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.last_ws <= 1'b1;
            q.word_ws <= 1'b1;
            q.cnt     <= CNT_W'(SAMP_W);
            q.sh      <= '0;
            q.left    <= '0;
            q.right   <= '0;
        end else begin
            q <= d;
        end
    end

    assign left  = q.left;
    assign right = q.right;
endmodule

// File: rtl/tlm_serializer.sv
module tlm_serializer #(
    parameter int SAMP_W  = tlm_pkg::SAMP_W,
    parameter int STAT_W  = tlm_pkg::STAT_W,
    parameter int STREAMS = tlm_pkg::STREAMS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             dbl,
    input  logic [STREAMS-1:0][SAMP_W-1:0]   left,
    input  logic [STREAMS-1:0][SAMP_W-1:0]   right,
    input  logic [2*STREAMS*STAT_W-1:0]      stat,
    output logic [1:0]                       sdo,
    output logic                             fsync
);
    localparam int SLOT_W   = SAMP_W + STAT_W;
    localparam int FRAME_W  = 2 * STREAMS * SLOT_W;
    localparam int POS_W    = $clog2(FRAME_W);
    localparam int BIT_W    = $clog2(SLOT_W);
    localparam int GRP_W    = $clog2(STREAMS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] MID_POS  = POS_W'(FRAME_W / 2 - 1);

    typedef struct packed {
        logic [POS_W-1:0]                   pos;
        logic [1:0][STREAMS-1:0][SLOT_W-1:0] grp;
        logic [1:0]                         sdo;
        logic                               fsync;
    } state_t;

    state_t d, q;
    logic [GRP_W-1:0] slot_i;
    logic [BIT_W-1:0] bidx;

    always_comb begin
        d = q;
        d.pos = q.pos + 1'b1;
        if (q.pos == LAST_POS || (dbl && q.pos == MID_POS)) begin
            for (int s = 0; s < STREAMS; s++) begin
                d.grp[0][s] = {left[s],  stat[(2*s)*STAT_W   +: STAT_W]};
                d.grp[1][s] = {right[s], stat[(2*s+1)*STAT_W +: STAT_W]};
            end
        end
        slot_i = d.pos[BIT_W +: GRP_W];
        bidx   = BIT_W'(SLOT_W - 1) - d.pos[BIT_W-1:0];
        for (int l = 0; l < 2; l++) begin
            d.sdo[l] = d.grp[l][slot_i][bidx];
        end
        d.fsync = (d.pos == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdo   = q.sdo;
    assign fsync = q.fsync;
endmodule

// File: rtl/tdm_lane_merger.sv
module tdm_lane_merger
    import tlm_pkg::*;
#(
    parameter int SAMP_W  = tlm_pkg::SAMP_W,
    parameter int STAT_W  = tlm_pkg::STAT_W,
    parameter int STREAMS = tlm_pkg::STREAMS,
    parameter int PAIRS   = tlm_pkg::PAIRS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$bits(ctl_t)-1:0]       cfg_wdata,
    input  logic                          i2s_strb,
    input  logic                          i2s_ws,
    input  logic [STREAMS-1:0]            i2s_sd,
    input  logic [2*STREAMS*STAT_W-1:0]   stat_in,
    output logic [2*PAIRS-1:0]            lane_sd,
    output logic [2*PAIRS-1:0]            lane_oe,
    output logic                          lane_fsync,
    output logic                          conv_rst,
    output logic                          conv_dbl,
    output logic                          conv_spd
);
    ctl_t                          ctl;
    logic [STREAMS-1:0][SAMP_W-1:0] left_w;
    logic [STREAMS-1:0][SAMP_W-1:0] right_w;
    logic [1:0]                    sdo;

    tlm_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctl   (ctl)
    );

    for (genvar k = 0; k < STREAMS; k++) begin : g_rx
        tlm_i2s_rx #(.SAMP_W(SAMP_W)) u_rx (
            .clk   (clk),
            .rst_n (rst_n),
            .strb  (i2s_strb),
            .ws    (i2s_ws),
            .sd    (i2s_sd[k]),
            .left  (left_w[k]),
            .right (right_w[k])
        );
    end

    tlm_serializer #(
        .SAMP_W  (SAMP_W),
        .STAT_W  (STAT_W),
        .STREAMS (STREAMS)
    ) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .dbl   (ctl.dbl),
        .left  (left_w),
        .right (right_w),
        .stat  (stat_in),
        .sdo   (sdo),
        .fsync (lane_fsync)
    );

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic en;
        assign en             = (ctl.sel == SEL_W'(p + 1));
        assign lane_oe[2*p]   = en;
        assign lane_oe[2*p+1] = en;
        assign lane_sd[2*p]   = en & sdo[0];
        assign lane_sd[2*p+1] = en & sdo[1];
    end

    assign conv_rst = ctl.conv_rst;
    assign conv_dbl = ctl.dbl;
    assign conv_spd = ctl.conv_spd;
endmodule

// File: rtl/tdm_lane_merger_chk.sv
module tdm_lane_merger_chk #(
    parameter int PAIRS = tlm_pkg::PAIRS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic               rst_bit,
    input logic [2*PAIRS-1:0] lane_sd,
    input logic [2*PAIRS-1:0] lane_oe,
    input logic               lane_fsync,
    input logic               conv_rst
);
    logic [PAIRS-1:0] pair_en;
    always_comb begin
        for (int p = 0; p < PAIRS; p++) begin
            pair_en[p] = lane_oe[2*p];
        end
    end

    // R3
    pair_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pair_en));

    for (genvar p = 0; p < PAIRS; p++) begin : g_p
        // R3
        pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_oe[2*p] == lane_oe[2*p+1]);
    end

    for (genvar i = 0; i < 2*PAIRS; i++) begin : g_l
        // R3
        idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_oe[i] |-> !lane_sd[i]);
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(lane_oe));

    // R10
    rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> conv_rst == $past(rst_bit));

    // R4
    fsync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_fsync |=> !lane_fsync);
endmodule

bind tdm_lane_merger tdm_lane_merger_chk #(.PAIRS(PAIRS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .rst_bit    (cfg_wdata[4]),
    .lane_sd    (lane_sd),
    .lane_oe    (lane_oe),
    .lane_fsync (lane_fsync),
    .conv_rst   (conv_rst)
);

// File: tb/tdm_lane_merger_test.sv
`timescale 1ns/1ps
module tdm_lane_merger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic        i2s_strb = 1'b0;
    logic        i2s_ws = 1'b1;
    logic [3:0]  i2s_sd = '0;
    logic [63:0] stat_in = '0;
    logic [5:0]  lane_sd, lane_oe;
    logic        lane_fsync, conv_rst, conv_dbl, conv_spd;

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] wl [4];
    logic [23:0] wr [4];
    logic [255:0] capl, capr;
    logic [3:0]   idle_oe, idle_sd;

    always #2 clk = ~clk;

    tdm_lane_merger uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .i2s_strb(i2s_strb), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd), .stat_in(stat_in),
        .lane_sd(lane_sd), .lane_oe(lane_oe), .lane_fsync(lane_fsync),
        .conv_rst(conv_rst), .conv_dbl(conv_dbl), .conv_spd(conv_spd)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input logic ws, input logic [3:0] sd);
        @(negedge clk);
        i2s_strb = 1'b1; i2s_ws = ws; i2s_sd = sd;
    endtask

    // one left word then one right word on all streams; bits past 24 are 1s
    task automatic send_set();
        logic [3:0] b;
        strobe(1'b1, 4'h0);
        for (int w = 0; w < 2; w++) begin
            strobe(w[0], 4'h0);
            for (int j = 0; j < 31; j++) begin
                for (int k = 0; k < 4; k++) begin
                    if (j < 24) b[k] = (w == 0) ? wl[k][23-j] : wr[k][23-j];
                    else b[k] = 1'b1;
                end
                strobe(w[0], b);
            end
        end
        @(negedge clk);
        i2s_strb = 1'b0; i2s_sd = '0;
    endtask

    task automatic wait_fsync();
        @(negedge clk);
        while (!lane_fsync) @(negedge clk);
    endtask

    // starts on the current negedge, which must be bit 0
    task automatic capture(input int p);
        idle_oe = '0; idle_sd = '0;
        for (int i = 0; i < 256; i++) begin
            capl[255-i] = lane_sd[2*p];
            capr[255-i] = lane_sd[2*p+1];
            for (int l = 0; l < 6; l++) begin
                if (l/2 != p) begin
                    idle_oe[(l < 2*p) ? l : l-2] |= lane_oe[l];
                    idle_sd[(l < 2*p) ? l : l-2] |= lane_sd[l];
                end
            end
            if (i != 255) @(negedge clk);
        end
    endtask

    function automatic logic [127:0] grp(input int lane, input logic [23:0] s0,
        input logic [23:0] s1, input logic [23:0] s2, input logic [23:0] s3);
        logic [23:0] s [4];
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        for (int k = 0; k < 4; k++)
            grp[127-32*k -: 32] = {s[k], stat_in[(2*k+lane)*8 +: 8]};
    endfunction

    logic [127:0] gl_a, gr_a, gl_b, gr_b;
    task automatic set_words(input logic [23:0] base);
        for (int k = 0; k < 4; k++) begin
            wl[k] = base ^ (24'h111111 * (k+1));
            wr[k] = ~base ^ (24'h0A0A0A * (k+1));
        end
    endtask

    task automatic t_reset();
        check("R1 oe", 256'(lane_oe), 256'(0));
        check("R1 sd", 256'(lane_sd), 256'(0));
        check("R1 conv", 256'({conv_rst, conv_dbl, conv_spd}), 256'(0));
    endtask

    task automatic t_cfg();
        cfg_write(5'b01010);  // pair 1, single speed, speed select
        check("R2 R3 oe pair1", 256'(lane_oe), 256'(6'b001100));
        check("R2 conv bits", 256'({conv_rst, conv_dbl, conv_spd}), 256'(3'b001));
    endtask

    task automatic t_single();
        stat_in = '0;
        set_words(24'hA5C3F1);
        send_set();
        gl_a = grp(0, wl[0], wl[1], wl[2], wl[3]);
        gr_a = grp(1, wr[0], wr[1], wr[2], wr[3]);
        wait_fsync();
        capture(1);
        check("R4 R5 R6 R9 left lane", capl, {gl_a, gl_a});
        check("R5 R6 right lane", capr, {gr_a, gr_a});
        check("R3 idle lanes", 256'({idle_oe, idle_sd}), 256'(0));
        set_words(24'h3C5A96);
        gl_b = grp(0, wl[0], wl[1], wl[2], wl[3]);
        gr_b = grp(1, wr[0], wr[1], wr[2], wr[3]);
        wait_fsync();
        fork
            capture(1);
            send_set();
        join
        check("R8 repeat left", capl, {gl_a, gl_a});
        check("R8 repeat right", capr, {gr_a, gr_a});
        wait_fsync();
        capture(1);
        check("R8 next frame", {capl[255:128], capr[255:128]}, {gl_b, gr_b});
    endtask

    task automatic t_double();
        cfg_write(5'b00111);  // pair 2, double speed
        check("R2 R3 oe pair2", 256'({lane_oe, conv_dbl, conv_spd}), 256'({6'b110000, 2'b10}));
        for (int c = 0; c < 8; c++) stat_in[8*c +: 8] = 8'h81 + 8'(c * 17);
        set_words(24'h9E2B47);
        send_set();
        gl_a = grp(0, wl[0], wl[1], wl[2], wl[3]);
        gr_a = grp(1, wr[0], wr[1], wr[2], wr[3]);
        wait_fsync();
        capture(2);
        check("R7 R9 steady left", capl, {gl_a, gl_a});
        check("R7 R9 steady right", capr, {gr_a, gr_a});
        set_words(24'h61D0E8);
        gl_b = grp(0, wl[0], wl[1], wl[2], wl[3]);
        gr_b = grp(1, wr[0], wr[1], wr[2], wr[3]);
        wait_fsync();
        fork
            capture(2);
            send_set();
        join
        check("R7 new half left", capl, {gl_a, gl_b});
        check("R7 new half right", capr, {gr_a, gr_b});
        check("R3 idle lanes dbl", 256'({idle_oe, idle_sd}), 256'(0));
    endtask

    task automatic t_conv_reset();
        cfg_write(5'b10000);
        check("R10 reset set", 256'({conv_rst, lane_oe}), 256'({1'b1, 6'b0}));
        cfg_write(5'b00000);
        check("R10 reset cleared", 256'(conv_rst), 256'(0));
        repeat (20) @(negedge clk);
        check("R2 hold without write", 256'({lane_oe, lane_sd}), 256'(0));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_single();
        t_double();
        t_conv_reset();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule